// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt event of a real-time-clock peripheral. It counts strobes of a 32.768 kHz time base that arrive as single-cycle `tick` pulses in the system clock domain. After a programmable number of strobes it emits a one-cycle event, together with the OR-mask that a neighbouring status unit applies to its flag register. The status unit itself, the bus interface and the calendar are outside this block.

A 4-bit rate code selects the interval, and a periodic-enable input gates the event. Code 0 always disables the event. Codes 1 and 2 are slow aliases that act as codes 8 and 9. Any other code n gives an interval of 2^(n-1) time-base strobes, so code 3 gives 4 strobes (about 122 µs) and code 15 gives 16384 strobes (500 ms). The divider restarts whenever the code changes, the enable toggles or the synchronous clear is pulsed, so the first event after such a change comes one full interval later. The block has no data stream: every pin is a plain control or status signal, and no back-pressure applies.

Top module: `periodic_rate_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `periodic_evt` is 0 and `flag_set` is 0.
- R2: With `pie_en` high and `rate_code` n in 3..15 held steady, consecutive events are exactly 2^(n-1) `tick` strobes apart.
- R3: Code 1 behaves as code 8, with events every 128 strobes. Code 2 behaves as code 9, with events every 256 strobes.
- R4: With `rate_code` 0, no event occurs, even when `pie_en` is high.
- R5: With `pie_en` low, no event occurs for any code.
- R6: A change of `rate_code` restarts the divider. A strobe on the edge where the change is seen is not counted, so the first event follows exactly one full new interval of later strobes.
- R7: A toggle of `pie_en`, or a cycle with `clr` high, restarts the divider in the same way. No event is raised on the edge where `clr` is sampled high.
- R8: `periodic_evt` is high for exactly one cycle per event. `flag_set` is 8'hC0 (bit 7 is the interrupt-request flag and bit 6 is the periodic flag) in that cycle, and 0 in every other cycle.
- R9: Only clock cycles with `tick` high advance the divider. An event appears in the cycle after the edge that samples the final strobe, and never after an edge where `tick` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous divider restart |
| tick | input | 1 | One-cycle strobe of the 32.768 kHz time base |
| rate_code | input | 4 | Interval select code |
| pie_en | input | 1 | Periodic event enable |
| periodic_evt | output | 1 | One-cycle periodic event |
| flag_set | output | 8 | Status flag OR-mask, 8'hC0 during an event |

## Verification
The bench sweeps every rate code with a strobe on every cycle and measures two consecutive intervals. This separates the exponent mapping of each code from the alias handling of codes 1 and 2 and from the disabled code 0. A sparse strobe pattern, with three idle cycles between strobes, shows that the divider counts strobes and not clock cycles. Restart scenarios change the code mid-interval with a strobe on the same edge, toggle the enable, and pulse the clear. They show that a restart discards the partial count and also the strobe that coincides with it.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    RC_OFF    = 2'd0,
    RC_ALIAS  = 2'd1,
    RC_DIRECT = 2'd2
  } rate_class_e;
endpackage

// File: rtl/rpg_rate_decode.sv
module rpg_rate_decode
  import rpg_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int ALIAS_TOP = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic              active,
  output logic [CODE_W-1:0] exponent
);
  rate_class_e       cls;
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    if (code == '0)
      cls = RC_OFF;
    else if (code <= CODE_W'(ALIAS_TOP))
      cls = RC_ALIAS;
    else
      cls = RC_DIRECT;
  end

  always_comb begin
    unique case (cls)
      RC_ALIAS:  eff_code = code + CODE_W'(ALIAS_ADD);
      RC_DIRECT: eff_code = code;
      default:   eff_code = CODE_W'(1);
    endcase
  end

  assign exponent = eff_code - CODE_W'(1);
  assign active   = enable && (cls != RC_OFF);
endmodule

// File: rtl/rpg_change_detect.sv
module rpg_change_detect #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic              reload
);
  logic [CODE_W-1:0] code_q;
  logic              enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      enable_q <= 1'b0;
    end else begin
      code_q   <= code;
      enable_q <= enable;
    end
  end

  assign reload = clr || (code != code_q) || (enable != enable_q);
endmodule

// File: rtl/rpg_tick_divider.sv
module rpg_tick_divider #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload,
  input  logic              active,
  input  logic [CODE_W-1:0] exponent,
  output logic              hit
);
  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign span    = {{CNT_W{1'b0}}, 1'b1} << exponent;
  assign last    = CNT_W'(span - 1'b1);
  assign at_last = (count == last);
  assign hit     = active && tick && !reload && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (reload || !active)
      count <= '0;
    else if (tick)
      count <= at_last ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/rpg_event_out.sv
module rpg_event_out #(
  parameter int          STAT_W    = 8,
  parameter logic [STAT_W-1:0] FLAG_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  output logic              evt,
  output logic [STAT_W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt  <= 1'b0;
      mask <= '0;
    end else begin
      evt  <= hit;
      mask <= hit ? FLAG_MASK : '0;
    end
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int                CODE_W    = 4,
  parameter int                STAT_W    = 8,
  parameter logic [STAT_W-1:0] FLAG_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  output logic              periodic_evt,
  output logic [STAT_W-1:0] flag_set
);
  localparam int CNT_W = (1 << CODE_W) - 2;

  logic              active;
  logic [CODE_W-1:0] exponent;
  logic              reload;
  logic              hit;

  rpg_rate_decode #(.CODE_W(CODE_W)) u_decode (
    .code     (rate_code),
    .enable   (pie_en),
    .active   (active),
    .exponent (exponent)
  );

  rpg_change_detect #(.CODE_W(CODE_W)) u_change (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .code   (rate_code),
    .enable (pie_en),
    .reload (reload)
  );

  rpg_tick_divider #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reload   (reload),
    .active   (active),
    .exponent (exponent),
    .hit      (hit)
  );

  rpg_event_out #(.STAT_W(STAT_W), .FLAG_MASK(FLAG_MASK)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .evt   (periodic_evt),
    .mask  (flag_set)
  );
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk #(
  parameter int                CODE_W    = 4,
  parameter int                STAT_W    = 8,
  parameter logic [STAT_W-1:0] FLAG_MASK = 8'hC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              tick,
  input logic [CODE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              periodic_evt,
  input logic [STAT_W-1:0] flag_set
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!periodic_evt && flag_set == '0);
    end
  end

  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_code) == '0) |-> !periodic_evt);

  assert_pie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pie_en) |-> !periodic_evt);

  assert_code_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_code) != $past(rate_code, 2)) |-> !periodic_evt);

  assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !periodic_evt);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |=> !periodic_evt);

  assert_mask_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |-> (flag_set == FLAG_MASK));

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic_evt |-> (flag_set == '0));

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> !periodic_evt);
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(
  .CODE_W(CODE_W), .STAT_W(STAT_W), .FLAG_MASK(FLAG_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .rate_code(rate_code),
  .pie_en(pie_en), .periodic_evt(periodic_evt), .flag_set(flag_set)
);

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       periodic_evt;
  logic [7:0] flag_set;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  periodic_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .rate_code(rate_code),
    .pie_en(pie_en), .periodic_evt(periodic_evt), .flag_set(flag_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock edge with the given strobe; returns the event seen after it
  task automatic step(input bit t, output bit e, inout int mask_bad);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    e = periodic_evt;
    if (flag_set != (e ? 8'hC0 : 8'h00)) mask_bad++;
  endtask

  task automatic set_cfg(input logic [3:0] code, input bit en);
    bit e;
    int mb = 0;
    rate_code = code;
    pie_en = en;
    step(1'b0, e, mb);
  endtask

  // strobes (every gap+1 cycles) until first event; returns strobe count
  task automatic ticks_to_event(input int limit, input int gap, output int n,
                                output int idle_evt, output int mask_bad);
    bit e;
    n = 0; idle_evt = 0; mask_bad = 0;
    while (n < limit) begin
      for (int g = 0; g < gap; g++) begin
        step(1'b0, e, mask_bad);
        if (e) idle_evt++;
      end
      step(1'b1, e, mask_bad);
      n++;
      if (e) break;
    end
    if (!e) n = -1;
    tick = 1'b0;
  endtask

  task automatic test_reset_R1();
    check(periodic_evt == 1'b0, "R1 evt during reset", periodic_evt, 0);
    check(flag_set == 8'h00, "R1 flags during reset", flag_set, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(periodic_evt == 1'b0, "R1 evt after reset", periodic_evt, 0);
    check(flag_set == 8'h00, "R1 flags after reset", flag_set, 0);
  endtask

  task automatic measure_code(input logic [3:0] code, input int exp_int, input string tag);
    int n1, n2, idle, mb1, mb2;
    set_cfg(code, 1'b1);
    ticks_to_event(exp_int + 4, 0, n1, idle, mb1);
    ticks_to_event(exp_int + 4, 0, n2, idle, mb2);
    check(n1 == exp_int, $sformatf("%s code %0d first interval", tag, code), n1, exp_int);
    check(n2 == exp_int, $sformatf("%s code %0d second interval", tag, code), n2, exp_int);
    check(mb1 + mb2 == 0, $sformatf("R8 code %0d flag mask mismatches", code), mb1 + mb2, 0);
  endtask

  task automatic test_direct_R2();
    for (int c = 3; c <= 15; c++) measure_code(4'(c), 1 << (c - 1), "R2");
  endtask

  task automatic test_alias_R3();
    measure_code(4'd1, 128, "R3");
    measure_code(4'd2, 256, "R3");
  endtask

  task automatic test_zero_code_R4();
    int n, idle, mb;
    set_cfg(4'd0, 1'b1);
    ticks_to_event(600, 0, n, idle, mb);
    check(n == -1, "R4 code 0 with enable produced event", n, -1);
  endtask

  task automatic test_pie_off_R5();
    int n, idle, mb;
    set_cfg(4'd3, 1'b0);
    ticks_to_event(300, 0, n, idle, mb);
    check(n == -1, "R5 enable low code 3 produced event", n, -1);
    set_cfg(4'd1, 1'b0);
    ticks_to_event(300, 0, n, idle, mb);
    check(n == -1, "R5 enable low code 1 produced event", n, -1);
  endtask

  task automatic test_rate_change_R6();
    int n, idle, mb;
    bit e;
    set_cfg(4'd3, 1'b1);
    step(1'b1, e, mb);
    step(1'b1, e, mb);
    rate_code = 4'd4;            // change with a strobe on the same edge
    step(1'b1, e, mb);
    check(e == 1'b0, "R6 event on change edge", e, 0);
    ticks_to_event(20, 0, n, idle, mb);
    check(n == 8, "R6 strobes after code change", n, 8);
  endtask

  task automatic test_restart_R7();
    int n, idle, mb;
    bit e;
    set_cfg(4'd3, 1'b1);
    step(1'b1, e, mb);
    step(1'b1, e, mb);
    step(1'b1, e, mb);
    set_cfg(4'd3, 1'b0);
    set_cfg(4'd3, 1'b1);
    ticks_to_event(20, 0, n, idle, mb);
    check(n == 4, "R7 strobes after enable toggle", n, 4);
    step(1'b1, e, mb);
    step(1'b1, e, mb);
    step(1'b1, e, mb);
    clr = 1'b1;                  // would be the terminal strobe
    step(1'b1, e, mb);
    clr = 1'b0;
    check(e == 1'b0, "R7 event on clear edge", e, 0);
    ticks_to_event(20, 0, n, idle, mb);
    check(n == 4, "R7 strobes after clear", n, 4);
  endtask

  task automatic test_sparse_R9();
    int n, idle, mb;
    set_cfg(4'd4, 1'b1);
    ticks_to_event(40, 3, n, idle, mb);
    check(n == 8, "R9 strobes with idle gaps", n, 8);
    check(idle == 0, "R9 events on idle cycles", idle, 0);
    ticks_to_event(40, 3, n, idle, mb);
    check(n == 8, "R9 second sparse interval", n, 8);
    check(mb == 0, "R8 flag mask in sparse run", mb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_R1();
    test_direct_R2();
    test_alias_R3();
    test_zero_code_R4();
    test_pie_off_R5();
    test_rate_change_R6();
    test_restart_R7();
    test_sparse_R9();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule